// File: doc/BRIEF.md
# Quad DAC Serial Write Master

This block sits on the host side of a four-channel digital-to-analog converter and turns one write request into a complete serial transaction. A request holds a 2-bit channel number, a 12-bit output code and a flag that says whether the converter outputs should be updated at once. The master drives an active-low chip select, a serial clock, serial data and an active-low load strobe. Every interval on those lines is a count of system clocks that software sets on configuration inputs.

The master accepts a request through a ready/valid handshake. The configuration counts and the request fields are captured when the request is accepted. The master then sends a 16-bit frame and closes the chip select. When the flag asks for it, the master also produces a load pulse on its own strobe line, timed with gaps before and after the pulse. The master takes a new request only after all of this has finished. A busy output follows the same condition as ready, inverted.

Top module: `dac_serial_master`

## Requirements
- R1: The frame holds 16 bits, sent in this order: the channel number (most significant bit first), two padding bits driven as 0, then the 12-bit code (most significant bit first). Bit k of the frame is the value on `dac_sdi` while `dac_sclk` is high for the k-th time.
- R2: `dac_cs_n` goes low in the first cycle after the accepting clock edge. It then stays low with `dac_sclk` low for max(`cfg_cs_setup`,1) cycles before `dac_sclk` first goes high.
- R3: Each high phase of `dac_sclk` lasts max(`cfg_sck_high`,2) cycles. Each low phase between two high phases lasts max(`cfg_sck_low`,2) cycles.
- R4: `dac_sdi` changes only in the cycle in which `dac_sclk` falls, or when the frame starts or ends. It is stable for as long as `dac_sclk` is high.
- R5: After the last high phase, `dac_cs_n` stays low with `dac_sclk` low for max(`cfg_cs_hold`,1) cycles and then rises. Each frame holds exactly 16 rising edges of `dac_sclk`, and `dac_sclk` is high only while `dac_cs_n` is low.
- R6: When the load flag is 1, `dac_ld_n` stays high for max(`cfg_ld_delay`,1) cycles after `dac_cs_n` rises. It then goes low for max(`cfg_ld_width`,1) cycles, and then stays high for max(`cfg_ld_recover`,1) more cycles before ready returns. When the flag is 0, `dac_ld_n` stays high and ready returns in the same cycle that `dac_cs_n` rises. `dac_ld_n` is never low while `dac_cs_n` is low.
- R7: `req_ready` is 1 only while idle, and `busy` is always its inverse. A request offered while `req_ready` is 0 is ignored and has no effect on the transaction in progress.
- R8: The request fields and all seven configuration counts are captured at the accepting edge. Changing them during a transaction has no effect on that transaction.
- R9: During and after reset, the outputs are `dac_cs_n`=1, `dac_sclk`=0, `dac_sdi`=0, `dac_ld_n`=1, `req_ready`=1 and `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Master is idle and will take a request |
| req_chan | input | 2 | Channel number to write |
| req_code | input | 12 | Output code |
| req_load | input | 1 | Pulse the load strobe after the frame |
| cfg_cs_setup | input | 8 | Chip-select-to-first-clock cycles |
| cfg_sck_high | input | 8 | Serial clock high cycles |
| cfg_sck_low | input | 8 | Serial clock low cycles |
| cfg_cs_hold | input | 8 | Last-clock-to-chip-select-rise cycles |
| cfg_ld_delay | input | 8 | Chip select rise to load strobe fall cycles |
| cfg_ld_width | input | 8 | Load strobe low cycles |
| cfg_ld_recover | input | 8 | Load strobe high cycles before ready |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_sclk | output | 1 | Serial clock |
| dac_sdi | output | 1 | Serial data |
| dac_ld_n | output | 1 | Load strobe, active low |
| busy | output | 1 | Transaction in progress |

## Verification
The assertions check these properties on every cycle:
- the serial clock is confined to the chip select window;
- data holds steady through each high phase;
- each clock phase lasts at least two cycles;
- the frame holds exactly 16 rising edges;
- the load strobe falls only with chip select high;
- ready and busy agree with the start of each frame.

Only the bench scenarios can show the bit order, the exact length of each phase under the clamped and large counts, and the load pulse gaps. They can also show that offers made while busy, and configuration changes during a frame, leave the waveform untouched.

// File: rtl/dac_ser_pkg.sv
package dac_ser_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SCK_HI,
    ST_SCK_LO,
    ST_HOLD,
    ST_LD_WAIT,
    ST_LD_PULSE,
    ST_LD_REC
  } seq_state_e;

  // Index of each timing count inside the packed configuration vector
  localparam int T_SETUP  = 0;
  localparam int T_SCK_HI = 1;
  localparam int T_SCK_LO = 2;
  localparam int T_HOLD   = 3;
  localparam int T_LD_DLY = 4;
  localparam int T_LD_W   = 5;
  localparam int T_LD_REC = 6;
  localparam int NUM_T    = 7;

  // Minimum number of cycles each timing count is clamped to
  function automatic int min_len(input int idx);
    return (idx == T_SCK_HI || idx == T_SCK_LO) ? 2 : 1;
  endfunction

endpackage

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/dac_timing_regs.sv
module dac_timing_regs
  import dac_ser_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        capture,
  input  logic [NUM_T-1:0][CNT_W-1:0] cfg_in,
  output logic [NUM_T-1:0][CNT_W-1:0] reload
);

  for (genvar gi = 0; gi < NUM_T; gi++) begin : g_field
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(min_len(gi));
    logic [CNT_W-1:0] held_q;
    logic [CNT_W-1:0] src;
    logic [CNT_W-1:0] eff;

    always_ff @(posedge clk) begin
      if (rst) begin
        held_q <= '0;
      end else if (capture) begin
        held_q <= cfg_in[gi];
      end
    end

    // At the accepting edge the live value is used; afterwards the held one
    assign src        = capture ? cfg_in[gi] : held_q;
    assign eff        = (src < MIN_V) ? MIN_V : src;
    assign reload[gi] = eff - 1'b1;
  end

endmodule

// File: rtl/dac_frame_shifter.sv
module dac_frame_shifter #(
  parameter int ADDR_W = 2,
  parameter int PAD_W  = 2,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [ADDR_W-1:0] chan,
  input  logic [CODE_W-1:0] code,
  output logic              msb_next
);

  localparam int FRAME_W = ADDR_W + PAD_W + CODE_W;

  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-1:0] sreg_q;
  logic [FRAME_W-1:0] sreg_n;

  if (PAD_W > 0) begin : g_pad
    assign frame = {chan, {PAD_W{1'b0}}, code};
  end else begin : g_nopad
    assign frame = {chan, code};
  end

  always_comb begin
    if (load) begin
      sreg_n = frame;
    end else if (shift) begin
      sreg_n = {sreg_q[FRAME_W-2:0], 1'b0};
    end else begin
      sreg_n = sreg_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
    end else begin
      sreg_q <= sreg_n;
    end
  end

  assign msb_next = sreg_n[FRAME_W-1];

endmodule

// File: rtl/dac_seq_fsm.sv
module dac_seq_fsm
  import dac_ser_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int FRAME_W = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic                        req_load,
  input  logic                        tmr_done,
  input  logic [NUM_T-1:0][CNT_W-1:0] reload,
  output seq_state_e                  st_q,
  output seq_state_e                  st_n,
  output logic                        accept,
  output logic                        tmr_load,
  output logic [CNT_W-1:0]            tmr_val,
  output logic                        sh_shift
);

  localparam int BIT_W = $clog2(FRAME_W);

  logic [BIT_W-1:0] bits_q;
  logic [BIT_W-1:0] bits_n;
  logic             ld_flag_q;

  always_comb begin
    st_n     = st_q;
    bits_n   = bits_q;
    accept   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_shift = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          st_n     = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = reload[T_SETUP];
          bits_n   = BIT_W'(FRAME_W - 1);
        end
      end
      ST_SETUP: begin
        if (tmr_done) begin
          st_n     = ST_SCK_HI;
          tmr_load = 1'b1;
          tmr_val  = reload[T_SCK_HI];
        end
      end
      ST_SCK_HI: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          if (bits_q == '0) begin
            st_n    = ST_HOLD;
            tmr_val = reload[T_HOLD];
          end else begin
            st_n     = ST_SCK_LO;
            tmr_val  = reload[T_SCK_LO];
            sh_shift = 1'b1;
          end
        end
      end
      ST_SCK_LO: begin
        if (tmr_done) begin
          st_n     = ST_SCK_HI;
          tmr_load = 1'b1;
          tmr_val  = reload[T_SCK_HI];
          bits_n   = bits_q - 1'b1;
        end
      end
      ST_HOLD: begin
        if (tmr_done) begin
          if (ld_flag_q) begin
            st_n     = ST_LD_WAIT;
            tmr_load = 1'b1;
            tmr_val  = reload[T_LD_DLY];
          end else begin
            st_n = ST_IDLE;
          end
        end
      end
      ST_LD_WAIT: begin
        if (tmr_done) begin
          st_n     = ST_LD_PULSE;
          tmr_load = 1'b1;
          tmr_val  = reload[T_LD_W];
        end
      end
      ST_LD_PULSE: begin
        if (tmr_done) begin
          st_n     = ST_LD_REC;
          tmr_load = 1'b1;
          tmr_val  = reload[T_LD_REC];
        end
      end
      ST_LD_REC: begin
        if (tmr_done) begin
          st_n = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      bits_q    <= '0;
      ld_flag_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      bits_q <= bits_n;
      if (accept) begin
        ld_flag_q <= req_load;
      end
    end
  end

endmodule

// File: rtl/dac_serial_master.sv
module dac_serial_master
  import dac_ser_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int PAD_W  = 2,
  parameter int CODE_W = 12,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_chan,
  input  logic [CODE_W-1:0] req_code,
  input  logic              req_load,
  input  logic [CNT_W-1:0]  cfg_cs_setup,
  input  logic [CNT_W-1:0]  cfg_sck_high,
  input  logic [CNT_W-1:0]  cfg_sck_low,
  input  logic [CNT_W-1:0]  cfg_cs_hold,
  input  logic [CNT_W-1:0]  cfg_ld_delay,
  input  logic [CNT_W-1:0]  cfg_ld_width,
  input  logic [CNT_W-1:0]  cfg_ld_recover,
  output logic              dac_cs_n,
  output logic              dac_sclk,
  output logic              dac_sdi,
  output logic              dac_ld_n,
  output logic              busy
);

  localparam int FRAME_W = ADDR_W + PAD_W + CODE_W;

  logic [NUM_T-1:0][CNT_W-1:0] cfg_vec;
  logic [NUM_T-1:0][CNT_W-1:0] reload;
  seq_state_e                  st_q;
  seq_state_e                  st_n;
  logic                        accept;
  logic                        tmr_load;
  logic [CNT_W-1:0]            tmr_val;
  logic                        tmr_done;
  logic                        sh_shift;
  logic                        msb_next;
  logic                        frame_n;

  assign cfg_vec[T_SETUP]  = cfg_cs_setup;
  assign cfg_vec[T_SCK_HI] = cfg_sck_high;
  assign cfg_vec[T_SCK_LO] = cfg_sck_low;
  assign cfg_vec[T_HOLD]   = cfg_cs_hold;
  assign cfg_vec[T_LD_DLY] = cfg_ld_delay;
  assign cfg_vec[T_LD_W]   = cfg_ld_width;
  assign cfg_vec[T_LD_REC] = cfg_ld_recover;

  dac_timing_regs #(.CNT_W(CNT_W)) i_timing (
    .clk     (clk),
    .rst     (rst),
    .capture (accept),
    .cfg_in  (cfg_vec),
    .reload  (reload)
  );

  dac_seq_fsm #(.CNT_W(CNT_W), .FRAME_W(FRAME_W)) i_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_load  (req_load),
    .tmr_done  (tmr_done),
    .reload    (reload),
    .st_q      (st_q),
    .st_n      (st_n),
    .accept    (accept),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .sh_shift  (sh_shift)
  );

  dac_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  dac_frame_shifter #(.ADDR_W(ADDR_W), .PAD_W(PAD_W), .CODE_W(CODE_W)) i_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .shift    (sh_shift),
    .chan     (req_chan),
    .code     (req_code),
    .msb_next (msb_next)
  );

  assign frame_n = (st_n == ST_SETUP) || (st_n == ST_SCK_HI) ||
                   (st_n == ST_SCK_LO) || (st_n == ST_HOLD);

  // Pin registers follow the state being entered, so pins and state agree
  always_ff @(posedge clk) begin
    if (rst) begin
      dac_cs_n <= 1'b1;
      dac_sclk <= 1'b0;
      dac_sdi  <= 1'b0;
      dac_ld_n <= 1'b1;
    end else begin
      dac_cs_n <= ~frame_n;
      dac_sclk <= (st_n == ST_SCK_HI);
      dac_sdi  <= frame_n & msb_next;
      dac_ld_n <= (st_n != ST_LD_PULSE);
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);

endmodule

// File: rtl/dac_serial_master_chk.sv
module dac_serial_master_chk #(
  parameter int FRAME_W = 16
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic dac_cs_n,
  input logic dac_sclk,
  input logic dac_sdi,
  input logic dac_ld_n
);

  localparam int CW = $clog2(FRAME_W + 1);

  logic [CW-1:0] rise_cnt;
  logic          sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_cnt <= '0;
      sclk_d   <= 1'b0;
    end else begin
      sclk_d <= dac_sclk;
      if (dac_cs_n) begin
        rise_cnt <= '0;
      end else if (dac_sclk && !sclk_d) begin
        rise_cnt <= rise_cnt + 1'b1;
      end
    end
  end

  AST_ACCEPT_OPENS_FRAME: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!dac_cs_n && busy && !req_ready)); // R2
  AST_CS_FALL_CLOCK_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(dac_cs_n) |-> !dac_sclk); // R2
  AST_SCLK_HIGH_MIN: assert property (@(posedge clk) disable iff (rst)
    $fell(dac_sclk) |-> $past(dac_sclk, 2)); // R3
  AST_SCLK_LOW_MIN: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_sclk) |-> !$past(dac_sclk, 2)); // R3
  AST_SDI_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    dac_sclk |-> $stable(dac_sdi)); // R4
  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    dac_sclk |-> !dac_cs_n); // R5
  AST_FRAME_EDGE_COUNT: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_cs_n) |-> (rise_cnt == CW'(FRAME_W))); // R5
  AST_LD_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (rst)
    !dac_ld_n |-> (dac_cs_n && !dac_sclk)); // R6
  AST_LD_FALL_AFTER_CS: assert property (@(posedge clk) disable iff (rst)
    $fell(dac_ld_n) |-> $past(dac_cs_n)); // R6
  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!busy && dac_cs_n && dac_ld_n)); // R7

endmodule

bind dac_serial_master dac_serial_master_chk #(.FRAME_W(ADDR_W + PAD_W + CODE_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .dac_cs_n  (dac_cs_n),
  .dac_sclk  (dac_sclk),
  .dac_sdi   (dac_sdi),
  .dac_ld_n  (dac_ld_n)
);

// File: tb/test_dac_serial_master.sv
`timescale 1ns/1ps
module test_dac_serial_master;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_chan = '0;
  logic [11:0] req_code = '0;
  logic        req_load = 1'b0;
  logic [7:0]  cfg_cs_setup, cfg_sck_high, cfg_sck_low, cfg_cs_hold;
  logic [7:0]  cfg_ld_delay, cfg_ld_width, cfg_ld_recover;
  logic        dac_cs_n, dac_sclk, dac_sdi, dac_ld_n, busy;

  always #2.5 clk = ~clk;

  dac_serial_master i_dac_serial_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_code(req_code), .req_load(req_load),
    .cfg_cs_setup(cfg_cs_setup), .cfg_sck_high(cfg_sck_high),
    .cfg_sck_low(cfg_sck_low), .cfg_cs_hold(cfg_cs_hold),
    .cfg_ld_delay(cfg_ld_delay), .cfg_ld_width(cfg_ld_width),
    .cfg_ld_recover(cfg_ld_recover),
    .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_sdi(dac_sdi),
    .dac_ld_n(dac_ld_n), .busy(busy)
  );

  // Expected pin tuple: {busy, cs_n, sclk, sdi, ld_n}
  localparam logic [4:0] IDLE_T = 5'b0_1_0_0_1;

  logic [4:0] q[$];
  logic [4:0] cur = IDLE_T;
  int         checks = 0;
  int         fails = 0;
  bit         finished = 0;
  string      cur_req = "R9";
  logic       prev_sclk = 1'b0;
  logic       prev_sdi = 1'b0;

  function automatic int eff(input logic [7:0] v, input int m);
    return (int'(v) < m) ? m : int'(v);
  endfunction

  function automatic void push_n(input int n, input logic cs, input logic sk,
                                 input logic sd, input logic ld);
    for (int i = 0; i < n; i++) q.push_back({1'b1, cs, sk, sd, ld});
  endfunction

  function automatic void build(input logic [1:0] a, input logic [11:0] c, input logic l);
    logic [15:0] f;
    f = {a, 2'b00, c};
    push_n(eff(cfg_cs_setup, 1), 1'b0, 1'b0, f[15], 1'b1);
    for (int i = 15; i >= 0; i--) begin
      push_n(eff(cfg_sck_high, 2), 1'b0, 1'b1, f[i], 1'b1);
      if (i > 0) push_n(eff(cfg_sck_low, 2), 1'b0, 1'b0, f[i-1], 1'b1);
    end
    push_n(eff(cfg_cs_hold, 1), 1'b0, 1'b0, f[0], 1'b1);
    if (l) begin
      push_n(eff(cfg_ld_delay, 1), 1'b1, 1'b0, 1'b0, 1'b1);
      push_n(eff(cfg_ld_width, 1), 1'b1, 1'b0, 1'b0, 1'b0);
      push_n(eff(cfg_ld_recover, 1), 1'b1, 1'b0, 1'b0, 1'b1);
    end
  endfunction

  // Reference model: advances on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      cur = IDLE_T;
    end else if (q.size() > 0) begin
      cur = q.pop_front();
    end else if (cur == IDLE_T && req_valid) begin
      build(req_chan, req_code, req_load);
      cur = q.pop_front();
    end else begin
      cur = IDLE_T;
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      checks++;
      if ({busy, dac_cs_n, dac_sclk, dac_sdi, dac_ld_n} !== cur || req_ready !== !cur[4]) begin
        fails++;
        $display("FAIL %s t=%0t {busy,cs_n,sclk,sdi,ld_n,ready} act=%b%b exp=%b%b",
                 cur_req, $time, {busy, dac_cs_n, dac_sclk, dac_sdi, dac_ld_n}, req_ready,
                 cur, !cur[4]);
      end
      // R4: data held while the serial clock stays high
      if (prev_sclk && dac_sclk) begin
        checks++;
        if (dac_sdi !== prev_sdi) begin
          fails++;
          $display("FAIL R4 t=%0t sdi moved during high phase act=%b exp=%b",
                   $time, dac_sdi, prev_sdi);
        end
      end
      prev_sclk = dac_sclk;
      prev_sdi  = dac_sdi;
    end
  end

  task automatic send(input logic [1:0] a, input logic [11:0] c, input logic l);
    req_chan  = a;
    req_code  = c;
    req_load  = l;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(cur == IDLE_T && q.size() == 0));
    @(negedge clk);
  endtask

  task automatic set_cfg(input int s, input int h, input int lo, input int hd,
                         input int dl, input int w, input int r);
    cfg_cs_setup = 8'(s); cfg_sck_high = 8'(h); cfg_sck_low = 8'(lo);
    cfg_cs_hold = 8'(hd); cfg_ld_delay = 8'(dl); cfg_ld_width = 8'(w);
    cfg_ld_recover = 8'(r);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    set_cfg(3, 2, 3, 2, 2, 3, 2);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state at the ports
    checks++;
    if ({dac_cs_n, dac_sclk, dac_sdi, dac_ld_n, req_ready, busy} !== 6'b100110) begin
      fails++;
      $display("FAIL R9 reset pins act=%b exp=100110",
               {dac_cs_n, dac_sclk, dac_sdi, dac_ld_n, req_ready, busy});
    end
    cur_req = "R1";
    send(2'b10, 12'hA5C, 1'b0);
    wait_idle();
    cur_req = "R6";
    send(2'b01, 12'h3C7, 1'b1);
    wait_idle();
    cur_req = "R3";
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    send(2'b11, 12'hFFF, 1'b1);
    wait_idle();
    cur_req = "R2";
    set_cfg(7, 5, 4, 6, 3, 5, 4);
    send(2'b00, 12'h000, 1'b0);
    send(2'b11, 12'h801, 1'b1);
    wait_idle();
    cur_req = "R8";
    set_cfg(2, 3, 2, 3, 2, 2, 2);
    send(2'b10, 12'h5A3, 1'b1);
    set_cfg(9, 9, 9, 9, 9, 9, 9);
    req_chan = 2'b01; req_code = 12'h0F0; req_load = 1'b0;
    wait_idle();
    cur_req = "R7";
    set_cfg(1, 2, 2, 1, 1, 1, 1);
    send(2'b01, 12'h6B9, 1'b0);
    req_chan = 2'b11; req_code = 12'hFFF; req_load = 1'b1; req_valid = 1'b1;
    repeat (20) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    cur_req = "R5";
    set_cfg(1, 4, 6, 8, 1, 2, 1);
    send(2'b00, 12'h924, 1'b1);
    wait_idle();
    cur_req = "R4";
    set_cfg(2, 2, 2, 1, 1, 1, 1);
    send(2'b10, 12'h555, 1'b0);
    wait_idle();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL R7 watchdog expired act=busy exp=idle");
      summary();
      $finish;
    end
  end

endmodule